// File: doc/BRIEF.md
# Channel Bit Error Counter

This block measures received bit errors on a framed serial link. It compares one of two things against a known value. The first is the seven bits of the frame alignment word, checked against a programmed alignment pattern. The second is the byte of one selected timeslot, checked against a programmable compare word. The count of differing bits in each compared byte is added to an 8-bit counter in one clock cycle, so one byte can add between zero and eight.

Software can overwrite the counter directly. It can also stage a value and load it by flipping a load bit. Two sticky flags record events. One is set whenever an applied increment changes the counter's least significant bit. The other is set whenever the counter wraps past FFh. Each flag has its own enable for the shared interrupt output. Finding the frame is done outside this block: the strobes come already aligned.

Top module: `bit_err_counter`

## Requirements
- R1: After reset, `err_count` is 00h, both flags are 0 and `irq` is 0.
- R2: When `src_sel` is 0 and `fas_stb` is high, the counter increases at the next edge by the number of positions where `rx_byte[6:0]` differs from `fas_pattern[6:0]`; `rx_byte[7]` is not compared in this mode.
- R3: When `src_sel` is 1 and `ts_stb` is high, the counter increases at the next edge by the number of positions where `rx_byte[7:0]` differs from `cmp_word[7:0]`.
- R4: A strobe that belongs to the unselected source (`ts_stb` while `src_sel` is 0, or `fas_stb` while `src_sel` is 1) leaves the counter and both flags unchanged.
- R5: The counter wraps modulo 256. An applied increment whose sum reaches 256 or more sets `ovf_flag`.
- R6: An applied increment that changes bit 0 of the counter (that is, an odd number of errored bits) sets `evt_flag`. An even, nonzero number of errored bits does not set it.
- R7: When `wr_en` is high, the counter takes `wr_data` at the next edge. This has priority over every other update, and the errors of that cycle are discarded and set no flag.
- R8: Every change of level on `load_tgl`, rising or falling, loads `stage_val` into the counter at the next edge. This ranks below `wr_en` and above error increments, whose errors are then discarded.
- R9: Each flag stays set until it is cleared by `clr_evt` or `clr_ovf`. If a set and a clear arrive in the same cycle, the set wins.
- R10: `irq` is high exactly when (`evt_flag` and `en_evt`) or (`ovf_flag` and `en_ovf`). A flag whose enable is low does not drive `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | 8 | Received byte under test |
| fas_stb | input | 1 | Marks a frame alignment byte on `rx_byte` |
| ts_stb | input | 1 | Marks the selected timeslot byte on `rx_byte` |
| src_sel | input | 1 | 0: alignment word source, 1: timeslot source |
| fas_pattern | input | 7 | Expected alignment bits |
| cmp_word | input | 8 | Expected timeslot byte |
| wr_en | input | 1 | Direct counter write |
| wr_data | input | 8 | Value for the direct write |
| load_tgl | input | 1 | Staged load bit; every level change loads |
| stage_val | input | 8 | Staged load value |
| clr_evt | input | 1 | Clears the event flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| en_evt | input | 1 | Lets the event flag drive `irq` |
| en_ovf | input | 1 | Lets the overflow flag drive `irq` |
| err_count | output | 8 | Current error count |
| evt_flag | output | 1 | Sticky LSB-change flag |
| ovf_flag | output | 1 | Sticky wrap flag |
| irq | output | 1 | Masked interrupt |

## Verification
The checker watches several properties on every cycle. A direct write lands exactly. The counter holds steady when no strobe, write or load is present. A flag can fall only after its clear, and can rise only with a matching change of the counter: a new LSB for the event flag and a smaller value after a wrap for the overflow flag. The interrupt stays low when no flag is set. The bench scenarios cover the rest. They check the exact popcount per byte in both source modes and the ignored bit 7 of the alignment byte. They also check the rejected strobes, the even-count case that leaves the event flag alone, the priority among write, load and increment, set winning over clear, and each enable acting alone.

// File: rtl/berc_pkg.sv
// Package: shared widths for the bit error counter.
// Assumes the alignment word fits inside the received byte.
package berc_pkg;
    localparam int BYTE_W = 8;
    localparam int FAS_W  = 7;
    localparam int CNT_W  = 8;
    localparam int ERR_W  = $clog2(BYTE_W + 1);
endpackage

// File: rtl/berc_mismatch.sv
// Module: berc_mismatch
// Counts the differing bits of one received byte against the expected value
// of the selected source. It is purely combinational.
// Assumes the alignment bits occupy the low FAS_W bits of the byte.
module berc_mismatch #(
    parameter int BYTE_W = 8,
    parameter int FAS_W  = 7,
    localparam int ERR_W = $clog2(BYTE_W + 1)
) (
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [FAS_W-1:0]  fas_pattern,
    input  logic [BYTE_W-1:0] cmp_word,
    input  logic              src_sel,
    input  logic              fas_stb,
    input  logic              ts_stb,
    output logic [ERR_W-1:0]  err_bits
);
    logic fas_hit;
    logic ts_hit;
    logic [BYTE_W-1:0] diff;

    assign fas_hit = fas_stb && !src_sel;
    assign ts_hit  = ts_stb && src_sel;

    // per-bit mismatch; the upper bits only take part in timeslot mode
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        if (i < FAS_W) begin : g_fas
            assign diff[i] = (fas_hit && (rx_byte[i] != fas_pattern[i])) ||
                             (ts_hit  && (rx_byte[i] != cmp_word[i]));
        end else begin : g_ts
            assign diff[i] = ts_hit && (rx_byte[i] != cmp_word[i]);
        end
    end

    // population count of the mismatch vector
    always_comb begin
        err_bits = '0;
        for (int k = 0; k < BYTE_W; k++) begin
            err_bits = err_bits + ERR_W'(diff[k]);
        end
    end
endmodule

// File: rtl/berc_counter.sv
// Module: berc_counter
// Holds the error count. Priority: direct write, then toggle-triggered
// staged load, then adding the errored-bit count. Reports flag-set pulses
// for the increments it applies.
// Assumes err_bits never exceeds 2**CNT_W - 1.
module berc_counter #(
    parameter int CNT_W = 8,
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_bits,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load_tgl,
    input  logic [CNT_W-1:0] stage_val,
    output logic [CNT_W-1:0] cnt,
    output logic             evt_set,
    output logic             ovf_set
);
    logic          load_q;
    logic          load_hit;
    logic          apply;
    logic [CNT_W:0] sum;

    assign load_hit = load_tgl != load_q;
    assign apply    = !wr_en && !load_hit && (err_bits != '0);
    assign sum      = {1'b0, cnt} + {{(CNT_W + 1 - ERR_W){1'b0}}, err_bits};
    assign evt_set  = apply && (sum[0] != cnt[0]);
    assign ovf_set  = apply && sum[CNT_W];

    // remember the load bit so that any level change can be seen
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= load_tgl;
    end

    // counter update with write > load > increment
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (wr_en)    cnt <= wr_data;
        else if (load_hit) cnt <= stage_val;
        else if (apply)    cnt <= sum[CNT_W-1:0];
    end
endmodule

// File: rtl/berc_flags.sv
// Module: berc_flags
// Sticky event and overflow flags plus the masked interrupt.
// Assumes set pulses come from berc_counter; set beats clear.
module berc_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_set,
    input  logic ovf_set,
    input  logic clr_evt,
    input  logic clr_ovf,
    input  logic en_evt,
    input  logic en_ovf,
    output logic evt_flag,
    output logic ovf_flag,
    output logic irq
);
    // event flag: set on an LSB change, held until cleared
    always_ff @(posedge clk) begin
        if (!rst_n)       evt_flag <= 1'b0;
        else if (evt_set) evt_flag <= 1'b1;
        else if (clr_evt) evt_flag <= 1'b0;
    end

    // overflow flag: set on a wrap, held until cleared
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (ovf_set) ovf_flag <= 1'b1;
        else if (clr_ovf) ovf_flag <= 1'b0;
    end

    // only enabled flags reach the interrupt output
    assign irq = (evt_flag && en_evt) || (ovf_flag && en_ovf);
endmodule

// File: rtl/bit_err_counter.sv
// Module: bit_err_counter (top)
// Bit error counter for the frame alignment word or one timeslot.
// Assumes the strobes are already aligned by an external framer.
module bit_err_counter
    import berc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              fas_stb,
    input  logic              ts_stb,
    input  logic              src_sel,
    input  logic [FAS_W-1:0]  fas_pattern,
    input  logic [BYTE_W-1:0] cmp_word,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              load_tgl,
    input  logic [CNT_W-1:0]  stage_val,
    input  logic              clr_evt,
    input  logic              clr_ovf,
    input  logic              en_evt,
    input  logic              en_ovf,
    output logic [CNT_W-1:0]  err_count,
    output logic              evt_flag,
    output logic              ovf_flag,
    output logic              irq
);
    logic [ERR_W-1:0] err_bits;
    logic             evt_set;
    logic             ovf_set;

    berc_mismatch #(.BYTE_W(BYTE_W), .FAS_W(FAS_W)) u_mis (
        .rx_byte(rx_byte), .fas_pattern(fas_pattern), .cmp_word(cmp_word),
        .src_sel(src_sel), .fas_stb(fas_stb), .ts_stb(ts_stb),
        .err_bits(err_bits)
    );

    berc_counter #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .err_bits(err_bits),
        .wr_en(wr_en), .wr_data(wr_data), .load_tgl(load_tgl),
        .stage_val(stage_val), .cnt(err_count),
        .evt_set(evt_set), .ovf_set(ovf_set)
    );

    berc_flags u_flg (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .ovf_set(ovf_set),
        .clr_evt(clr_evt), .clr_ovf(clr_ovf), .en_evt(en_evt), .en_ovf(en_ovf),
        .evt_flag(evt_flag), .ovf_flag(ovf_flag), .irq(irq)
    );
endmodule

// File: rtl/bit_err_counter_chk.sv
// Module: bit_err_counter_chk
// Cycle-by-cycle properties of bit_err_counter, attached by bind.
module bit_err_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fas_stb,
    input logic       ts_stb,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       load_tgl,
    input logic       load_q,
    input logic       clr_evt,
    input logic       clr_ovf,
    input logic [7:0] err_count,
    input logic       evt_flag,
    input logic       ovf_flag,
    input logic       irq
);
    // R7
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> err_count == $past(wr_data));

    // R4
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fas_stb && !ts_stb && !wr_en && (load_tgl == load_q)) |=> $stable(err_count));

    // R9
    evt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_flag) |-> $past(clr_evt));

    // R9
    ovf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> $past(clr_ovf));

    // R5
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (err_count < $past(err_count)));

    // R6
    evt_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flag) |-> (err_count[0] != $past(err_count[0])));

    // R10
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_flag && !ovf_flag) |-> !irq);
endmodule

bind bit_err_counter bit_err_counter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fas_stb(fas_stb), .ts_stb(ts_stb),
    .wr_en(wr_en), .wr_data(wr_data), .load_tgl(load_tgl),
    .load_q(u_cnt.load_q), .clr_evt(clr_evt), .clr_ovf(clr_ovf),
    .err_count(err_count), .evt_flag(evt_flag), .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/tb_bit_err_counter.sv
// Directed bench for bit_err_counter: one task per scenario.
module tb_bit_err_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       fas_stb = 1'b0;
    logic       ts_stb = 1'b0;
    logic       src_sel = 1'b0;
    logic [6:0] fas_pattern = 7'h1B;
    logic [7:0] cmp_word = 8'hA5;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       load_tgl = 1'b0;
    logic [7:0] stage_val = '0;
    logic       clr_evt = 1'b0;
    logic       clr_ovf = 1'b0;
    logic       en_evt = 1'b0;
    logic       en_ovf = 1'b0;
    logic [7:0] err_count;
    logic       evt_flag;
    logic       ovf_flag;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bit_err_counter dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .fas_stb(fas_stb),
        .ts_stb(ts_stb), .src_sel(src_sel), .fas_pattern(fas_pattern),
        .cmp_word(cmp_word), .wr_en(wr_en), .wr_data(wr_data),
        .load_tgl(load_tgl), .stage_val(stage_val), .clr_evt(clr_evt),
        .clr_ovf(clr_ovf), .en_evt(en_evt), .en_ovf(en_ovf),
        .err_count(err_count), .evt_flag(evt_flag), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one edge; inputs change and outputs are sampled on the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        fas_stb = 0; ts_stb = 0; wr_en = 0; clr_evt = 0; clr_ovf = 0;
    endtask

    task automatic preset(input logic [7:0] v);
        wr_en = 1; wr_data = v; step(); idle();
        clr_evt = 1; clr_ovf = 1; step(); idle();
    endtask

    task automatic t_reset();
        check("R1 count", err_count, 0);
        check("R1 evt", evt_flag, 0);
        check("R1 ovf", ovf_flag, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_fas();
        preset(8'h00);
        src_sel = 0; fas_stb = 1;
        rx_byte = {1'b1, 7'h1B}; step(); idle();   // only bit 7 differs, ignored
        check("R2 bit7 ignored", err_count, 0);
        fas_stb = 1; rx_byte = {1'b0, 7'h1B ^ 7'h45}; step(); idle(); // 3 errors
        check("R2 three errors", err_count, 3);
        fas_stb = 1; rx_byte = {1'b0, ~7'h1B}; step(); idle(); // 7 errors
        check("R2 seven errors", err_count, 10);
    endtask

    task automatic t_chan();
        preset(8'h20);
        src_sel = 1; ts_stb = 1; rx_byte = ~8'hA5; step(); idle();
        check("R3 eight errors", err_count, 8'h28);
        ts_stb = 1; rx_byte = 8'hA5 ^ 8'h81; step(); idle();
        check("R3 msb and lsb", err_count, 8'h2A);
    endtask

    task automatic t_ignore();
        preset(8'h40);
        src_sel = 0; ts_stb = 1; rx_byte = 8'hFF; step(); idle();
        check("R4 ts in fas mode", err_count, 8'h40);
        src_sel = 1; fas_stb = 1; rx_byte = 8'h00; step(); idle();
        check("R4 fas in ts mode", err_count, 8'h40);
        check("R4 flags", {evt_flag, ovf_flag}, 0);
    endtask

    task automatic t_wrap();
        preset(8'hFE);
        src_sel = 1; ts_stb = 1; rx_byte = 8'hA5 ^ 8'h07; step(); idle();
        check("R5 wrap value", err_count, 8'h01);
        check("R5 ovf set", ovf_flag, 1);
    endtask

    task automatic t_event();
        preset(8'h10);
        src_sel = 0; fas_stb = 1; rx_byte = {1'b0, 7'h1B ^ 7'h03}; step(); idle();
        check("R6 even count value", err_count, 8'h12);
        check("R6 even no evt", evt_flag, 0);
        fas_stb = 1; rx_byte = {1'b0, 7'h1B ^ 7'h40}; step(); idle();
        check("R6 odd evt", evt_flag, 1);
    endtask

    task automatic t_write();
        preset(8'h05);
        src_sel = 1; ts_stb = 1; rx_byte = 8'h5A; wr_en = 1; wr_data = 8'h77;
        step(); idle();
        check("R7 write wins", err_count, 8'h77);
        check("R7 no flags", {evt_flag, ovf_flag}, 0);
    endtask

    task automatic t_load();
        preset(8'h05);
        stage_val = 8'h3C; step();
        check("R8 staged only", err_count, 8'h05);
        load_tgl = ~load_tgl; src_sel = 1; ts_stb = 1; rx_byte = 8'h5A; step(); idle();
        check("R8 rise loads", err_count, 8'h3C);
        check("R8 errors dropped", evt_flag, 0);
        stage_val = 8'hC3; load_tgl = ~load_tgl; step();
        check("R8 fall loads", err_count, 8'hC3);
        stage_val = 8'h11; load_tgl = ~load_tgl; wr_en = 1; wr_data = 8'h22; step(); idle();
        check("R8 below write", err_count, 8'h22);
    endtask

    task automatic t_sticky();
        preset(8'hFF);
        src_sel = 1; ts_stb = 1; rx_byte = 8'hA4; step(); idle(); // 1 error, wraps
        check("R9 both set", {evt_flag, ovf_flag}, 2'b11);
        step(); step();
        check("R9 held", {evt_flag, ovf_flag}, 2'b11);
        clr_evt = 1; step(); idle();
        check("R9 evt cleared", {evt_flag, ovf_flag}, 2'b01);
        clr_evt = 1; ts_stb = 1; rx_byte = 8'hA4; step(); idle();
        check("R9 set beats clear", evt_flag, 1);
    endtask

    task automatic t_irq();
        // flags from t_sticky: both set
        en_evt = 0; en_ovf = 0; step();
        check("R10 all masked", irq, 0);
        en_evt = 1; step();
        check("R10 evt only", irq, 1);
        en_evt = 0; en_ovf = 1; clr_ovf = 1; step(); idle();
        check("R10 ovf cleared", irq, 0);
        en_evt = 1; clr_evt = 1; step(); idle();
        check("R10 all clear", irq, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_fas();
        t_chan();
        t_ignore();
        t_wrap();
        t_event();
        t_write();
        t_load();
        t_sticky();
        t_irq();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule